// File: doc/BRIEF.md
# Auto-Advancing Indirect Memory Window

This block gives a host a narrow path into a word-organised internal SRAM that the host cannot address directly. Four registers on a small host register bus make up the path. Two of them hold byte pointers, one for reads and one for writes. A third accepts a data word to store. The fourth returns a data word from the memory. Software first loads a pointer. After that it reaches successive words just by touching the matching data register again and again. Each data access moves its own pointer on by one 32-bit word.

The read pointer and the write pointer are independent of each other. A stream of writes can therefore run alongside a stream of reads, and neither disturbs the other. A data write reaches the single-port synchronous SRAM in the cycle it is presented, with no wait. A data read has to wait for the memory's one-cycle latency, so the block holds `hst_ready` low for one cycle. When the host reads back a pointer register, it gets the pointer's present value, including any advances already made.

Top module: `sram_window`

## Requirements
- R1: After synchronous reset both pointers are zero, and reading either pointer register returns 0.
- R2: A host write to the read-pointer register (host offset 0x40C) or to the write-pointer register (offset 0x410) loads all 32 bits of the write data into that pointer. A later read of that register returns the value unchanged.
- R3: A host write to the write-data register (offset 0x418) issues exactly one SRAM write in that same cycle (`mem_en`=1, `mem_we`=1), carrying the host data to word index `wptr[MEM_AW+1:2]`. After that cycle the write pointer has increased by 4.
- R4: A host read of the read-data register (offset 0x41C) has `hst_ready` low in its first cycle, and in that cycle the block issues an SRAM read (`mem_en`=1, `mem_we`=0) at word index `rptr[MEM_AW+1:2]`. In the next cycle `hst_ready` is high and `hst_rdata` carries that word. After the completing cycle the read pointer has increased by 4.
- R5: A data access through one pointer leaves the other pointer unchanged.
- R6: Pointer bits 1:0 and all bits above `MEM_AW+1` play no part in SRAM indexing. A pointer holding 0xFFFFFFFC wraps to 0 when it advances.
- R7: Every register access other than a read-data read completes with `hst_ready` high in the same cycle. Within the window, offset 0x414 is unmapped: reading it returns 0, and writing it changes neither pointer.
- R8: `mem_en` is low in any cycle with no data-register access issuing a memory operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_addr | input | HOST_AW | Host register byte address |
| hst_wr | input | 1 | Host write strobe |
| hst_wdata | input | 32 | Host write data |
| hst_rd | input | 1 | Host read strobe, held until hst_ready |
| hst_rdata | output | 32 | Host read data, valid when hst_ready |
| hst_ready | output | 1 | Access completes at the next clock edge |
| mem_en | output | 1 | SRAM access enable |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | MEM_AW | SRAM word index |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data, one cycle after a read enable |

## Verification
The SRAM strobes for a data write are expected in the same cycle as `hst_wr`. The bench therefore samples them shortly after the falling edge on which it raised the write strobe, which is before the edge that commits the write. For a read-data access, the bench checks that `hst_ready` is low just after the request is driven and high one falling edge later, with the memory word on `hst_rdata`. This gives exactly one wait cycle. Pointer advances are checked by reading back the pointer registers only after the committing edge has passed, and those readbacks must themselves complete with no wait.

// File: rtl/sram_window_pkg.sv
package sram_window_pkg;

    localparam int WORD_W    = 32;
    localparam int WORD_STEP = 4;

    localparam logic [31:0] WIN_BASE    = 32'h0000_0400;
    localparam logic [31:0] OFS_RPTR    = 32'h0000_000C;
    localparam logic [31:0] OFS_WPTR    = 32'h0000_0010;
    localparam logic [31:0] OFS_WDATA   = 32'h0000_0018;
    localparam logic [31:0] OFS_RDATA   = 32'h0000_001C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RPTR,
        SEL_WPTR,
        SEL_WDATA,
        SEL_RDATA
    } win_sel_e;

    typedef enum logic {
        RD_IDLE,
        RD_WAIT
    } rd_state_e;

    typedef struct packed {
        logic              load;
        logic              step;
        logic [WORD_W-1:0] val;
    } ptr_cmd_t;

    function automatic win_sel_e decode_sel(input logic [31:0] a);
        win_sel_e s;
        if (a == WIN_BASE + OFS_RPTR)       s = SEL_RPTR;
        else if (a == WIN_BASE + OFS_WPTR)  s = SEL_WPTR;
        else if (a == WIN_BASE + OFS_WDATA) s = SEL_WDATA;
        else if (a == WIN_BASE + OFS_RDATA) s = SEL_RDATA;
        else                                s = SEL_NONE;
        return s;
    endfunction

    function automatic logic [WORD_W-1:0] next_word(input logic [WORD_W-1:0] p);
        return p + WORD_W'(WORD_STEP);
    endfunction

endpackage

// File: rtl/swin_decode.sv
module swin_decode
    import sram_window_pkg::*;
#(
    parameter int HOST_AW = 12
) (
    input  logic [HOST_AW-1:0] addr,
    output win_sel_e           sel
);

    always_comb begin
        sel = decode_sel(32'(addr));
    end

endmodule

// File: rtl/swin_ptr.sv
module swin_ptr
    import sram_window_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ptr_cmd_t          cmd,
    output logic [WORD_W-1:0] value
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (cmd.load) begin
            value <= cmd.val;
        end else if (cmd.step) begin
            value <= next_word(value);
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> value == '0);

    assert_load_full_R2: assert property (@(posedge clk) disable iff (rst)
        $past(cmd.load && !rst) |-> value == $past(cmd.val));

    assert_step_word_R3: assert property (@(posedge clk) disable iff (rst)
        $past(cmd.step && !cmd.load && !rst) |-> value == $past(value) + 32'd4);

    assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd.step && !cmd.load && !rst) && $past(value) == 32'hFFFF_FFFC)
        |-> value == 32'd0);

endmodule

// File: rtl/swin_rd_seq.sv
module swin_rd_seq
    import sram_window_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic issue,
    output logic done
);

    rd_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        issue    = 1'b0;
        done     = 1'b0;
        unique case (state)
            RD_IDLE: begin
                if (req) begin
                    issue    = 1'b1;
                    state_nx = RD_WAIT;
                end
            end
            RD_WAIT: begin
                done     = 1'b1;
                state_nx = RD_IDLE;
            end
            default: state_nx = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= RD_IDLE;
        else     state <= state_nx;
    end

    assert_issue_then_done_R4: assert property (@(posedge clk) disable iff (rst)
        issue |=> done);

    assert_single_completion_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/sram_window.sv
module sram_window
    import sram_window_pkg::*;
#(
    parameter int HOST_AW = 12,
    parameter int MEM_AW  = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [HOST_AW-1:0] hst_addr,
    input  logic               hst_wr,
    input  logic [31:0]        hst_wdata,
    input  logic               hst_rd,
    output logic [31:0]        hst_rdata,
    output logic               hst_ready,
    output logic               mem_en,
    output logic               mem_we,
    output logic [MEM_AW-1:0]  mem_addr,
    output logic [31:0]        mem_wdata,
    input  logic [31:0]        mem_rdata
);

    localparam int IDX_LO  = 2;
    localparam int IDX_HI  = MEM_AW + IDX_LO - 1;
    localparam int N_PTR   = 2;
    localparam int P_READ  = 0;
    localparam int P_WRITE = 1;

    win_sel_e           sel;
    logic               wr_cyc;
    logic               rd_cyc;
    logic               rd_req;
    logic               rd_issue;
    logic               rd_done;
    logic               wr_issue;
    ptr_cmd_t           cmd [N_PTR];
    logic [WORD_W-1:0]  ptr [N_PTR];

    swin_decode #(.HOST_AW(HOST_AW)) u_dec (
        .addr (hst_addr),
        .sel  (sel)
    );

    assign wr_cyc = hst_wr;
    assign rd_cyc = hst_rd && !hst_wr;
    assign rd_req = rd_cyc && (sel == SEL_RDATA);

    swin_rd_seq u_rdseq (
        .clk   (clk),
        .rst   (rst),
        .req   (rd_req),
        .issue (rd_issue),
        .done  (rd_done)
    );

    assign wr_issue = wr_cyc && (sel == SEL_WDATA);

    always_comb begin
        cmd[P_READ].load  = wr_cyc && (sel == SEL_RPTR);
        cmd[P_READ].step  = rd_done;
        cmd[P_READ].val   = hst_wdata;
        cmd[P_WRITE].load = wr_cyc && (sel == SEL_WPTR);
        cmd[P_WRITE].step = wr_issue;
        cmd[P_WRITE].val  = hst_wdata;
    end

    for (genvar g = 0; g < N_PTR; g++) begin : g_ptr
        swin_ptr u_ptr (
            .clk   (clk),
            .rst   (rst),
            .cmd   (cmd[g]),
            .value (ptr[g])
        );
    end

    always_comb begin
        mem_en    = wr_issue || rd_issue;
        mem_we    = wr_issue;
        mem_wdata = hst_wdata;
        if (wr_issue) mem_addr = ptr[P_WRITE][IDX_HI:IDX_LO];
        else          mem_addr = ptr[P_READ][IDX_HI:IDX_LO];
    end

    always_comb begin
        hst_ready = !rd_issue;
        if (rd_done) begin
            hst_rdata = mem_rdata;
        end else begin
            unique case (sel)
                SEL_RPTR: hst_rdata = ptr[P_READ];
                SEL_WPTR: hst_rdata = ptr[P_WRITE];
                default:  hst_rdata = '0;
            endcase
        end
    end

    assert_mem_only_on_access_R8: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (hst_wr || hst_rd));

    assert_write_keeps_rptr_R5: assert property (@(posedge clk) disable iff (rst)
        wr_issue |=> $stable(ptr[P_READ]));

    assert_read_keeps_wptr_R5: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> $stable(ptr[P_WRITE]));

    assert_hole_no_effect_R7: assert property (@(posedge clk) disable iff (rst)
        (hst_wr && sel == SEL_NONE) |=> ($stable(ptr[P_READ]) && $stable(ptr[P_WRITE])));

    assert_we_needs_host_write_R3: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (hst_wr && mem_en));

endmodule

// File: tb/sim_sram_window.sv
module sim_sram_window;

    localparam int CLK_PERIOD = 10;
    localparam int HOST_AW    = 12;
    localparam int MEM_AW     = 4;
    localparam int DEPTH      = 1 << MEM_AW;

    localparam logic [11:0] A_RPTR  = 12'h40C;
    localparam logic [11:0] A_WPTR  = 12'h410;
    localparam logic [11:0] A_HOLE  = 12'h414;
    localparam logic [11:0] A_WDATA = 12'h418;
    localparam logic [11:0] A_RDATA = 12'h41C;

    logic               clk = 1'b0;
    logic               rst;
    logic [HOST_AW-1:0] hst_addr;
    logic               hst_wr;
    logic [31:0]        hst_wdata;
    logic               hst_rd;
    logic [31:0]        hst_rdata;
    logic               hst_ready;
    logic               mem_en;
    logic               mem_we;
    logic [MEM_AW-1:0]  mem_addr;
    logic [31:0]        mem_wdata;
    logic [31:0]        mem_rdata;

    logic [31:0] model   [DEPTH];
    logic [31:0] exp_mem [DEPTH];
    logic [31:0] exp_rptr;
    logic [31:0] exp_wptr;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sram_window #(.HOST_AW(HOST_AW), .MEM_AW(MEM_AW)) u0 (
        .clk       (clk),
        .rst       (rst),
        .hst_addr  (hst_addr),
        .hst_wr    (hst_wr),
        .hst_wdata (hst_wdata),
        .hst_rd    (hst_rd),
        .hst_rdata (hst_rdata),
        .hst_ready (hst_ready),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) model[mem_addr] <= mem_wdata;
            else        mem_rdata <= model[mem_addr];
        end
    end

    function automatic logic [31:0] pat(input int i);
        return (32'h9E37_79B9 * 32'(i + 1)) ^ 32'h5A00_00A5;
    endfunction

    function automatic int idx_of(input logic [31:0] p);
        return int'(p[MEM_AW+1:2]);
    endfunction

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic hwrite(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        hst_addr = a; hst_wdata = d; hst_wr = 1'b1;
        #1;
        chk("R7 write ready", 32'(hst_ready), 32'd1);
        if (a == A_WDATA) begin
            chk("R3 mem_en", 32'(mem_en), 32'd1);
            chk("R3 mem_we", 32'(mem_we), 32'd1);
            chk("R3/R6 mem_addr", 32'(mem_addr), 32'(idx_of(exp_wptr)));
            chk("R3 mem_wdata", mem_wdata, d);
            exp_mem[idx_of(exp_wptr)] = d;
            exp_wptr = exp_wptr + 32'd4;
        end else begin
            chk("R8 mem_en idle on write", 32'(mem_en), 32'd0);
            if (a == A_RPTR) exp_rptr = d;
            if (a == A_WPTR) exp_wptr = d;
        end
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic hread(input logic [11:0] a, output logic [31:0] d, output int waits);
        @(negedge clk);
        hst_addr = a; hst_rd = 1'b1; waits = 0;
        #1;
        if (a == A_RDATA) begin
            chk("R4 issue mem_en", 32'(mem_en), 32'd1);
            chk("R4 issue mem_we", 32'(mem_we), 32'd0);
            chk("R4/R6 issue index", 32'(mem_addr), 32'(idx_of(exp_rptr)));
        end else begin
            chk("R8 mem_en idle on read", 32'(mem_en), 32'd0);
        end
        while (!hst_ready && waits < 8) begin
            @(negedge clk);
            #1;
            waits++;
        end
        d = hst_rdata;
        @(negedge clk);
        hst_rd = 1'b0;
    endtask

    task automatic read_data_check(input string r);
        logic [31:0] d;
        int w;
        logic [31:0] e;
        e = exp_mem[idx_of(exp_rptr)];
        hread(A_RDATA, d, w);
        chk({r, " R4 data"}, d, e);
        chk("R4 one wait cycle", 32'(w), 32'd1);
        exp_rptr = exp_rptr + 32'd4;
    endtask

    task automatic ptr_check(input string r);
        logic [31:0] d;
        int w;
        hread(A_RPTR, d, w);
        chk({r, " rptr"}, d, exp_rptr);
        chk("R7 rptr no wait", 32'(w), 32'd0);
        hread(A_WPTR, d, w);
        chk({r, " wptr"}, d, exp_wptr);
        chk("R7 wptr no wait", 32'(w), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        logic [31:0] d;
        int w;
        rst = 1'b1; hst_addr = '0; hst_wr = 1'b0; hst_wdata = '0; hst_rd = 1'b0;
        exp_rptr = '0; exp_wptr = '0;
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state of both pointers, R8 idle
        #1;
        chk("R8 idle after reset", 32'(mem_en), 32'd0);
        ptr_check("R1 reset");

        // R3: fill the whole memory through the write stream
        hwrite(A_WPTR, 32'd0);
        for (int i = 0; i < DEPTH; i++) hwrite(A_WDATA, pat(i));
        ptr_check("R3/R5 after fill");

        // R4: stream back, then one more read wraps the index (R6)
        hwrite(A_RPTR, 32'd0);
        for (int i = 0; i < DEPTH; i++) read_data_check("R4 stream");
        ptr_check("R4/R5 after stream");
        read_data_check("R6 index wrap");

        // R6: ignored low and high pointer bits, sweep every index
        for (int s = 0; s < DEPTH; s++) begin
            logic [31:0] a;
            a = (32'(s) << 2) | (32'(s) & 32'd3) | (32'(s) << 8);
            hwrite(A_WPTR, a);
            hwrite(A_WDATA, ~pat(s));
            ptr_check("R2/R6 sweep load");
        end
        for (int s = 0; s < DEPTH; s++) begin
            logic [31:0] a;
            a = (32'(DEPTH - 1 - s) << 2) | 32'd3 | 32'hABC0_0000;
            hwrite(A_RPTR, a);
            read_data_check("R6 sweep read");
        end

        // R6: full pointer wrap
        hwrite(A_WPTR, 32'hFFFF_FFFC);
        hwrite(A_WDATA, 32'h1357_9BDF);
        ptr_check("R6 pointer wrap");
        hwrite(A_RPTR, 32'hFFFF_FFFC);
        read_data_check("R6 wrap read");
        ptr_check("R6 read pointer wrap");

        // R7: unmapped hole
        hwrite(A_HOLE, 32'hFFFF_FFFF);
        ptr_check("R7 hole write");
        hread(A_HOLE, d, w);
        chk("R7 hole reads zero", d, 32'd0);
        chk("R7 hole no wait", 32'(w), 32'd0);

        // R5: interleaved independent streams
        hwrite(A_WPTR, 32'h20);
        hwrite(A_RPTR, 32'h00);
        for (int k = 0; k < 8; k++) begin
            hwrite(A_WDATA, pat(100 + k));
            read_data_check("R5 interleave");
            ptr_check("R5 interleave");
        end
        hwrite(A_RPTR, 32'h20);
        for (int k = 0; k < 8; k++) read_data_check("R5 interleave verify");

        // R2: arbitrary full-width loads
        hwrite(A_RPTR, 32'hDEAD_BEE7);
        hwrite(A_WPTR, 32'h8000_0001);
        ptr_check("R2 full load");

        report();
    end

endmodule